// File: doc/BRIEF.md
# Page Write Buffer and Programming Sequencer

This block sits behind a serial memory bus engine and turns a write transaction into a timed programming operation. The engine hands it a start address, each data byte it accepted, a start event, a stop event tagged with the bit slot in which the stop arrived, and the level of the write-protect input. The sequencer keeps up to one page of bytes in a buffer and records which locations were written.

Only a stop that lands in slot 10 after at least one data byte launches programming. That is the slot right after a data byte's acknowledge. Any other stop throws the buffer away. Once launched, the block raises busy for a fixed number of clocks and, inside that window, copies every written buffer location to the memory array through a simple write port. While busy it ignores the bus engine entirely.

The low address bits wrap inside the page. The upper address bits select the page and stay fixed for the whole transaction.

Top module: `page_program_seq`

## Requirements
- R1: After reset, busy and mem_we are low and no array write takes place.
- R2: A transaction carrying one data byte, ended by a stop with stop_slot equal to 10, writes that byte to the loaded address.
- R3: Several data bytes are written to consecutive addresses, starting at the loaded address.
- R4: The low log2(PAGE_BYTES) address bits wrap within the page. A byte past the page size overwrites the earlier byte at the same offset, and no write leaves the page given by the upper address bits.
- R5: A stop with stop_slot other than 10 does not raise busy, and the buffered bytes are discarded without being written.
- R6: A stop in slot 10 with no data byte since the address load does not raise busy.
- R7: A launching stop raises busy at the next clock edge. Busy then stays high for exactly WRITE_CYCLES clocks.
- R8: While busy, the start, address, data and stop inputs have no effect. This covers the pointer, the buffer and any further launch.
- R9: If wprot_in is high in any cycle from the start event up to and including the address-load cycle, the data bytes are not stored and no programming starts.
- R10: wprot_in going high after the address-load cycle does not block the write.
- R11: Only buffer locations written in the current transaction reach the array. There is one array write per distinct offset, and every array write happens while busy is high.
- R12: A start event arriving before a launching stop clears all buffered bytes.
- R13: When busy drops, cur_addr holds the address that follows the last byte written, wrapped within the page.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_evt | input | 1 | One-cycle pulse: start condition seen |
| addr_load | input | 1 | One-cycle pulse: both address bytes received |
| addr_in | input | ADDR_W | Full byte address, valid with addr_load |
| wprot_in | input | 1 | Write-protect level |
| data_valid | input | 1 | One-cycle pulse: a data byte was accepted |
| data_in | input | DATA_W | Data byte, valid with data_valid |
| stop_evt | input | 1 | One-cycle pulse: stop condition seen |
| stop_slot | input | 4 | Bit slot of the stop within the byte frame (10 = just after the acknowledge) |
| busy | output | 1 | Programming in progress |
| mem_we | output | 1 | Array write strobe |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | DATA_W | Array write data |
| cur_addr | output | ADDR_W | Current address pointer |

## Verification
The bench builds the block with ADDR_W=10, PAGE_BYTES=8 and WRITE_CYCLES=20. The small page lets a ten-byte transaction exercise the wrap and the overwrite of early offsets with only a few pulses. The short busy window still exceeds the page scan, so the bench can count the exact busy length and can inject a whole ignored transaction while busy is high. A 1024-entry array model behind the write port lets every test confirm that untouched neighbours, including the next page, keep their contents.

// File: rtl/pws_pkg.sv
package pws_pkg;
  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_DATA} phase_t;
  localparam int SLOT_W = 4;
  localparam logic [SLOT_W-1:0] ARM_SLOT = 4'd10;
endpackage

// File: rtl/pws_page_buffer.sv
module pws_page_buffer #(
  parameter int PAGE_BYTES = 128,
  parameter int DATA_W     = 8,
  localparam int IDX_W     = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              clr,
  input  logic              rd_en,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0]     ram [PAGE_BYTES];
  logic [PAGE_BYTES-1:0] valid_q;

  // storage array: no reset, single write port, registered read
  always_ff @(posedge clk) begin
    if (wr_en) ram[wr_idx] <= wr_data;
    if (rd_en) rd_data <= ram[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en && valid_q[rd_idx];
      if (clr)        valid_q <= '0;
      else if (wr_en) valid_q[wr_idx] <= 1'b1;
    end
  end
endmodule

// File: rtl/pws_capture.sv
module pws_capture
  import pws_pkg::*;
#(
  parameter int ADDR_W = 17,
  parameter int IDX_W  = 7
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy_i,
  input  logic              start_evt,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wprot_in,
  input  logic              data_valid,
  input  logic              stop_evt,
  input  logic [SLOT_W-1:0] stop_slot,
  output logic              buf_wr,
  output logic [IDX_W-1:0]  buf_idx,
  output logic              discard,
  output logic              launch,
  output logic [ADDR_W-1:0] ptr_o
);
  phase_t            phase_q;
  logic              inh_q;
  logic              got_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              active;

  always_comb begin
    active  = !busy_i;
    buf_idx = ptr_q[IDX_W-1:0];
    buf_wr  = active && (phase_q == PH_DATA) && data_valid && !inh_q
              && !start_evt && !stop_evt;
    launch  = active && stop_evt && !start_evt && (phase_q == PH_DATA)
              && got_q && !inh_q && (stop_slot == ARM_SLOT);
    discard = active && (start_evt || (stop_evt && !launch));
    ptr_o   = ptr_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      inh_q   <= 1'b0;
      got_q   <= 1'b0;
      ptr_q   <= '0;
    end else if (active) begin
      if (start_evt) begin
        phase_q <= PH_ADDR;
        inh_q   <= wprot_in;
        got_q   <= 1'b0;
      end else if (stop_evt) begin
        phase_q <= PH_IDLE;
        got_q   <= 1'b0;
      end else begin
        if (phase_q == PH_ADDR) begin
          inh_q <= inh_q | wprot_in;
          if (addr_load) begin
            ptr_q   <= addr_in;
            phase_q <= PH_DATA;
          end
        end
        if (buf_wr) begin
          ptr_q[IDX_W-1:0] <= ptr_q[IDX_W-1:0] + 1'b1;
          got_q            <= 1'b1;
        end
      end
    end
  end

  // a launching stop is followed by busy at the next edge
  p_launch_busy_r7: assert property (@(posedge clk) disable iff (rst)
    launch |=> busy_i);
  // the pointer is frozen while programming
  p_ptr_hold_r8: assert property (@(posedge clk) disable iff (rst)
    busy_i |=> $stable(ptr_q));
endmodule

// File: rtl/pws_commit.sv
module pws_commit #(
  parameter int ADDR_W       = 17,
  parameter int PAGE_BYTES   = 128,
  parameter int WRITE_CYCLES = 500,
  localparam int IDX_W       = $clog2(PAGE_BYTES),
  localparam int PG_W        = ADDR_W - IDX_W,
  localparam int CNT_W       = $clog2(WRITE_CYCLES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              launch,
  input  logic [PG_W-1:0]   page_i,
  output logic              busy_o,
  output logic              rd_en,
  output logic [IDX_W-1:0]  rd_idx,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr_o
);
  logic             busy_q;
  logic [CNT_W-1:0] cnt_q;

  always_comb begin
    busy_o = busy_q;
    rd_en  = busy_q && (cnt_q < CNT_W'(PAGE_BYTES));
    rd_idx = cnt_q[IDX_W-1:0];
    done   = busy_q && (cnt_q == CNT_W'(WRITE_CYCLES - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      cnt_q      <= '0;
      mem_addr_o <= '0;
    end else begin
      if (!busy_q && launch) begin
        busy_q <= 1'b1;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (done) begin
          busy_q <= 1'b0;
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
      if (rd_en) mem_addr_o <= {page_i, rd_idx};
    end
  end
endmodule

// File: rtl/page_program_seq.sv
module page_program_seq
  import pws_pkg::*;
#(
  parameter int ADDR_W       = 17,
  parameter int DATA_W       = 8,
  parameter int PAGE_BYTES   = 128,
  parameter int WRITE_CYCLES = 500,
  localparam int IDX_W       = $clog2(PAGE_BYTES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_evt,
  input  logic              addr_load,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              wprot_in,
  input  logic              data_valid,
  input  logic [DATA_W-1:0] data_in,
  input  logic              stop_evt,
  input  logic [3:0]        stop_slot,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [ADDR_W-1:0] cur_addr
);
  logic             buf_wr, discard, launch, done, rd_en;
  logic [IDX_W-1:0] buf_idx, rd_idx;

  initial begin
    assert (WRITE_CYCLES > PAGE_BYTES)
      else $error("WRITE_CYCLES must exceed PAGE_BYTES");
  end

  pws_capture #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_cap (
    .clk(clk), .rst(rst), .busy_i(busy),
    .start_evt(start_evt), .addr_load(addr_load), .addr_in(addr_in),
    .wprot_in(wprot_in), .data_valid(data_valid),
    .stop_evt(stop_evt), .stop_slot(stop_slot),
    .buf_wr(buf_wr), .buf_idx(buf_idx), .discard(discard),
    .launch(launch), .ptr_o(cur_addr)
  );

  pws_page_buffer #(.PAGE_BYTES(PAGE_BYTES), .DATA_W(DATA_W)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(buf_wr), .wr_idx(buf_idx), .wr_data(data_in),
    .clr(discard || done),
    .rd_en(rd_en), .rd_idx(rd_idx),
    .rd_data(mem_wdata), .rd_valid(mem_we)
  );

  pws_commit #(.ADDR_W(ADDR_W), .PAGE_BYTES(PAGE_BYTES),
               .WRITE_CYCLES(WRITE_CYCLES)) u_cmt (
    .clk(clk), .rst(rst), .launch(launch),
    .page_i(cur_addr[ADDR_W-1:IDX_W]),
    .busy_o(busy), .rd_en(rd_en), .rd_idx(rd_idx), .done(done),
    .mem_addr_o(mem_addr)
  );

  // array writes only inside the busy window
  p_we_in_busy_r11: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> busy);
  // array writes never leave the transaction's page
  p_addr_in_page_r4: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> (mem_addr[ADDR_W-1:IDX_W] == cur_addr[ADDR_W-1:IDX_W]));
  // a stop in a wrong slot never starts programming
  p_bad_stop_r5: assert property (@(posedge clk) disable iff (rst)
    (stop_evt && stop_slot != ARM_SLOT && !busy) |=> !busy);
endmodule

// File: tb/page_program_seq_test.sv
module page_program_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 10;
  localparam int DW = 8;
  localparam int PB = 8;
  localparam int WC = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start_evt = 0, addr_load = 0, wprot_in = 0, data_valid = 0, stop_evt = 0;
  logic [AW-1:0] addr_in = '0;
  logic [DW-1:0] data_in = '0;
  logic [3:0]    stop_slot = '0;
  logic          busy, mem_we;
  logic [AW-1:0] mem_addr, cur_addr;
  logic [DW-1:0] mem_wdata;

  int checks = 0, fails = 0, wr_count = 0;
  logic [DW-1:0] model [1<<AW];

  always #(CLK_PERIOD/2) clk = ~clk;

  page_program_seq #(.ADDR_W(AW), .DATA_W(DW), .PAGE_BYTES(PB), .WRITE_CYCLES(WC)) uut (
    .clk(clk), .rst(rst), .start_evt(start_evt), .addr_load(addr_load), .addr_in(addr_in),
    .wprot_in(wprot_in), .data_valid(data_valid), .data_in(data_in),
    .stop_evt(stop_evt), .stop_slot(stop_slot), .busy(busy), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .cur_addr(cur_addr)
  );

  always_ff @(posedge clk) begin
    if (mem_we) begin
      model[mem_addr] <= mem_wdata;
      wr_count <= wr_count + 1;
    end
  end

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_start();
    @(negedge clk) start_evt = 1; @(negedge clk) start_evt = 0;
  endtask
  task automatic do_addr(input logic [AW-1:0] a);
    @(negedge clk) begin addr_load = 1; addr_in = a; end
    @(negedge clk) addr_load = 0;
  endtask
  task automatic do_data(input logic [DW-1:0] d);
    @(negedge clk) begin data_valid = 1; data_in = d; end
    @(negedge clk) data_valid = 0;
  endtask
  task automatic do_stop(input logic [3:0] s);
    @(negedge clk) begin stop_evt = 1; stop_slot = s; end
    @(negedge clk) stop_evt = 0;
  endtask
  // counts busy cycles seen at negedges, starting at the current one
  task automatic busy_len(output int n);
    n = 0;
    while (busy && n < 1000) begin n++; @(negedge clk); end
  endtask
  task automatic idle_check(input string req);
    int seen = 0;
    for (int i = 0; i < 6; i++) begin @(negedge clk); if (busy) seen++; end
    check(req, seen, 0);
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 mem_we", mem_we, 0);
    check("R1 writes", wr_count, 0);
  endtask

  task automatic t_byte_write();
    int n; int w0 = wr_count;
    do_start(); do_addr(10'h123); do_data(8'hA5); do_stop(4'd10);
    check("R7 busy at stop+1", busy, 1);
    busy_len(n);
    check("R7 busy length", n, WC);
    check("R2 byte", model[10'h123], 8'hA5);
    check("R11 single write", wr_count - w0, 1);
    check("R11 neighbour", model[10'h124], 8'hEE);
    check("R13 pointer", cur_addr, 10'h124);
  endtask

  task automatic t_page_write();
    int n; int w0 = wr_count;
    do_start(); do_addr(10'h200);
    for (int i = 0; i < 5; i++) do_data(8'h10 + 8'(i));
    do_stop(4'd10); busy_len(n);
    for (int i = 0; i < 5; i++) check("R3 page byte", model[10'h200 + i], 8'h10 + i);
    check("R11 untouched offset", model[10'h205], 8'hEE);
    check("R11 write count", wr_count - w0, 5);
    check("R13 pointer", cur_addr, 10'h205);
  endtask

  task automatic t_wrap();
    int n; int w0 = wr_count;
    do_start(); do_addr(10'h306);
    for (int i = 0; i < 10; i++) do_data(8'hD0 + 8'(i));
    do_stop(4'd10); busy_len(n);
    // byte i goes to offset (6+i)%8; offsets 6,7 overwritten by bytes 8,9
    check("R4 off6", model[10'h306], 8'hD8);
    check("R4 off7", model[10'h307], 8'hD9);
    for (int k = 0; k < 6; k++) check("R4 low offsets", model[10'h300 + k], 8'hD2 + k);
    check("R4 next page", model[10'h308], 8'hEE);
    check("R4 writes", wr_count - w0, 8);
    check("R13 wrapped pointer", cur_addr, 10'h300);
  endtask

  task automatic t_bad_slot();
    int n;
    do_start(); do_addr(10'h040); do_data(8'h77); do_stop(4'd9);
    idle_check("R5 no busy");
    check("R5 memory", model[10'h040], 8'hEE);
    // a following valid transaction in the same page must not carry the old byte
    do_start(); do_addr(10'h041); do_data(8'h78); do_stop(4'd10); busy_len(n);
    check("R5 discarded byte", model[10'h040], 8'hEE);
    check("R5 new byte", model[10'h041], 8'h78);
  endtask

  task automatic t_no_data();
    do_start(); do_addr(10'h050); do_stop(4'd10);
    idle_check("R6 no busy");
  endtask

  task automatic t_inhibit();
    int w0 = wr_count;
    wprot_in = 1; do_start(); wprot_in = 0;
    do_addr(10'h060); do_data(8'h61); do_stop(4'd10);
    idle_check("R9 no busy (high at start)");
    do_start();
    @(negedge clk) begin addr_load = 1; addr_in = 10'h062; wprot_in = 1; end
    @(negedge clk) begin addr_load = 0; wprot_in = 0; end
    do_data(8'h63); do_stop(4'd10);
    idle_check("R9 no busy (high at address)");
    check("R9 memory 060", model[10'h060], 8'hEE);
    check("R9 memory 062", model[10'h062], 8'hEE);
    check("R9 writes", wr_count - w0, 0);
  endtask

  task automatic t_late_wprot();
    int n;
    do_start(); do_addr(10'h070); wprot_in = 1; do_data(8'h71); do_stop(4'd10);
    check("R10 busy", busy, 1);
    busy_len(n); wprot_in = 0;
    check("R10 byte", model[10'h070], 8'h71);
  endtask

  task automatic t_restart();
    int n; int w0 = wr_count;
    do_start(); do_addr(10'h080); do_data(8'h11);
    do_start(); do_addr(10'h083); do_data(8'h22); do_stop(4'd10); busy_len(n);
    check("R12 cleared byte", model[10'h080], 8'hEE);
    check("R12 new byte", model[10'h083], 8'h22);
    check("R12 writes", wr_count - w0, 1);
  endtask

  task automatic t_busy_ignore();
    int n;
    do_start(); do_addr(10'h0A0); do_data(8'h33); do_stop(4'd10);
    do_start(); do_addr(10'h0B0); do_data(8'h44); do_stop(4'd10);
    check("R8 still busy", busy, 1);
    check("R8 pointer frozen", cur_addr, 10'h0A1);
    busy_len(n);
    idle_check("R8 no relaunch");
    check("R8 ignored data", model[10'h0B0], 8'hEE);
    check("R8 first byte", model[10'h0A0], 8'h33);
    check("R8 pointer", cur_addr, 10'h0A1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    for (int i = 0; i < (1<<AW); i++) model[i] = 8'hEE;
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_byte_write();
    t_page_write();
    t_wrap();
    t_bad_slot();
    t_no_data();
    t_inhibit();
    t_late_wprot();
    t_restart();
    t_busy_ignore();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule